// File: doc/BRIEF.md
# Arithmetic RAM Fill Sequencer

This block drives one port of a dual-port block RAM and fills it with a counting pattern. A processor on the other port reads the pattern back. After reset is released the sequencer starts on its own. It clears its counters, then writes one full data word per clock cycle for a fixed number of locations, then stops and raises a done flag. A one-cycle start pulse in the finished state runs the sequence again from location zero.

Word k of a run holds k times a step value. The step value is one of four constants, picked by a two-bit switch input. The switch is sampled once, when the counters are cleared, and that sampled value is shown on two LED outputs for the rest of the run. From this side the port is byte addressed and starts at zero, so each word moves the address forward by the word size in bytes. The port reset, port enable and byte write enables all have defined values in every state. The port reset is released, and the enables are raised, only in the cycles that carry a word to be written.

Top module: `seq_fill_writer`

## Requirements
- R1: After rst is released the sequence starts without a start pulse. One idle cycle and one clear cycle pass, and the first write appears in the second cycle after the first clock edge with rst low.
- R2: A run presents exactly WORD_COUNT (1000 by default) writes in consecutive cycles, one per clock, with every bit of ramWe set (all byte lanes of the word at once).
- R3: The address of word k of a run is 4*k for 32-bit data (k times the word size in bytes), starting at zero.
- R4: The data of word k is k*step modulo 2^32, so the first word is zero. The step comes from stepSel: 00 gives 0x04000004, 01 gives 0x04040404, 10 gives 0x00000004, 11 gives 0x00000001.
- R5: stepSel is sampled in the clear cycle, and selLed shows the sampled code from the first write until the next clear cycle. Changing stepSel at any other time has no effect on ramWrData or selLed.
- R6: ramRst is low and ramEn is high exactly in the cycles where ramWe is nonzero. In every other cycle ramRst is 1, ramEn is 0 and ramWe is 0.
- R7: In every cycle that is not a write, ramAddr and ramWrData are zero.
- R8: done rises in the cycle after the last write. It then stays high, with no writes, until a start pulse arrives.
- R9: A start pulse seen while done is high lowers done in the next cycle and begins a new run from address 0 and data 0, with the first write two cycles after the start edge. A start pulse during the write phase is ignored.
- R10: A synchronous active-high rst, asserted at any time, gives done=0, selLed=00, ramRst=1, ramEn=0, ramWe=0 and a zero address and data bus from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and the RAM port |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart pulse, acted on only while done is high |
| stepSel | input | 2 | Switch code that picks the data step |
| ramEn | output | 1 | RAM port enable |
| ramRst | output | 1 | Active-high RAM port reset |
| ramWe | output | 4 | Byte-lane write enables |
| ramAddr | output | 32 | Byte address on the RAM port |
| ramWrData | output | 32 | Write data on the RAM port |
| selLed | output | 2 | Step code sampled for the current run |
| done | output | 1 | Run finished |

## Verification
The assertions compare each write with the write in the cycle before. They therefore take for granted that rst stays low for the whole of a run. A reset in the middle of a run is only seen by the properties as the end of the write phase, and the run-length property is disabled while rst is high. The bench asserts reset during a run only once. It then lets the sequence restart by itself and checks the new run from its first word. stepSel and start are treated as asynchronous to the run and may change in any cycle. The bench moves both of them during the write phase to show that they have no effect there.

// File: rtl/seq_fill_pkg.sv
package seq_fill_pkg;

  // Sequencer phases; IDLE is the reset phase, INIT clears and samples.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } fillState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearCnt;  // zero address, data and word counters
    logic latchSel;  // sample the step switch
    logic advance;   // step counters after the current write
    logic writeOn;   // current cycle carries a write
  } fillCtl_t;

endpackage

// File: rtl/seq_fill_dpath.sv
module seq_fill_dpath
  import seq_fill_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_COUNT = 1000,
  parameter int unsigned SEL_W      = 2,
  parameter logic [DATA_W-1:0] STEP0 = 32'h0400_0004,
  parameter logic [DATA_W-1:0] STEP1 = 32'h0404_0404,
  parameter logic [DATA_W-1:0] STEP2 = 32'h0000_0004,
  parameter logic [DATA_W-1:0] STEP3 = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  fillCtl_t          ctl,
  input  logic [SEL_W-1:0]  stepSel,
  output logic              lastWord,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic [SEL_W-1:0]  selLed
);

  localparam int unsigned CNT_W = $clog2(WORD_COUNT);
  localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(DATA_W / 8);
  localparam logic [CNT_W-1:0]  LAST_IDX  = CNT_W'(WORD_COUNT - 1);

  logic [CNT_W-1:0]  wordCnt;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [SEL_W-1:0]  selReg;
  logic [DATA_W-1:0] stepVal;

  // Step chosen by the sampled switch code.
  always_comb begin
    case (selReg[1:0])
      2'b00:   stepVal = STEP0;
      2'b01:   stepVal = STEP1;
      2'b10:   stepVal = STEP2;
      default: stepVal = STEP3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordCnt <= '0;
      addrReg <= '0;
      dataReg <= '0;
      selReg  <= '0;
    end else begin
      if (ctl.clearCnt) begin
        wordCnt <= '0;
        addrReg <= '0;
        dataReg <= '0;
      end else if (ctl.advance) begin
        wordCnt <= wordCnt + CNT_W'(1);
        addrReg <= addrReg + BYTE_STEP;
        dataReg <= dataReg + stepVal;
      end
      if (ctl.latchSel) begin
        selReg <= stepSel;
      end
    end
  end

  assign lastWord  = (wordCnt == LAST_IDX);
  assign ramAddr   = ctl.writeOn ? addrReg : '0;
  assign ramWrData = ctl.writeOn ? dataReg : '0;
  assign selLed    = selReg;

endmodule

// File: rtl/seq_fill_ctrl.sv
module seq_fill_ctrl
  import seq_fill_pkg::*;
#(
  parameter int unsigned WE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            lastWord,
  output fillCtl_t        ctl,
  output logic            ramEn,
  output logic            ramRst,
  output logic [WE_W-1:0] ramWe,
  output logic            done
);

  fillState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    ctl.clearCnt = 1'b0;
    ctl.latchSel = 1'b0;
    ctl.advance  = 1'b0;
    ctl.writeOn  = 1'b0;
    case (state)
      ST_IDLE: stateNext = ST_INIT;
      ST_INIT: begin
        ctl.clearCnt = 1'b1;
        ctl.latchSel = 1'b1;
        stateNext    = ST_WRITE;
      end
      ST_WRITE: begin
        ctl.writeOn = 1'b1;
        ctl.advance = 1'b1;
        if (lastWord) stateNext = ST_DONE;
      end
      default: begin
        if (start) stateNext = ST_INIT;
      end
    endcase
  end

  // All port controls are defined in every phase.
  assign ramEn  = ctl.writeOn;
  assign ramRst = ~ctl.writeOn;
  assign ramWe  = {WE_W{ctl.writeOn}};
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/seq_fill_writer.sv
module seq_fill_writer
  import seq_fill_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_COUNT = 1000,
  parameter int unsigned SEL_W      = 2,
  parameter logic [DATA_W-1:0] STEP0 = 32'h0400_0004,
  parameter logic [DATA_W-1:0] STEP1 = 32'h0404_0404,
  parameter logic [DATA_W-1:0] STEP2 = 32'h0000_0004,
  parameter logic [DATA_W-1:0] STEP3 = 32'h0000_0001,
  localparam int unsigned WE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  stepSel,
  output logic              ramEn,
  output logic              ramRst,
  output logic [WE_W-1:0]   ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic [SEL_W-1:0]  selLed,
  output logic              done
);

  fillCtl_t ctl;
  logic     lastWord;

  seq_fill_ctrl #(.WE_W(WE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lastWord (lastWord),
    .ctl      (ctl),
    .ramEn    (ramEn),
    .ramRst   (ramRst),
    .ramWe    (ramWe),
    .done     (done)
  );

  seq_fill_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_COUNT(WORD_COUNT), .SEL_W(SEL_W),
    .STEP0(STEP0), .STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .stepSel   (stepSel),
    .lastWord  (lastWord),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .selLed    (selLed)
  );

endmodule

// File: rtl/seq_fill_chk.sv
module seq_fill_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_COUNT = 1000,
  parameter int unsigned SEL_W      = 2,
  parameter logic [DATA_W-1:0] STEP0 = 32'h0400_0004,
  parameter logic [DATA_W-1:0] STEP1 = 32'h0404_0404,
  parameter logic [DATA_W-1:0] STEP2 = 32'h0000_0004,
  parameter logic [DATA_W-1:0] STEP3 = 32'h0000_0001,
  localparam int unsigned WE_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              ramEn,
  input logic              ramRst,
  input logic [WE_W-1:0]   ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [DATA_W-1:0] ramWrData,
  input logic [SEL_W-1:0]  selLed,
  input logic              done
);

  localparam int unsigned RUN_W = $clog2(WORD_COUNT) + 1;
  localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(DATA_W / 8);

  logic [DATA_W-1:0] ledStep;
  logic [RUN_W-1:0]  runCnt;

  always_comb begin
    case (selLed[1:0])
      2'b00:   ledStep = STEP0;
      2'b01:   ledStep = STEP1;
      2'b10:   ledStep = STEP2;
      default: ledStep = STEP3;
    endcase
  end

  // Writes so far in the current run of consecutive writes.
  always_ff @(posedge clk) begin
    if (rst)        runCnt <= '0;
    else if (ramEn) runCnt <= runCnt + RUN_W'(1);
    else            runCnt <= '0;
  end

  a_r6_write_ctrl: assert property (@(posedge clk) disable iff (rst)
    (ramWe != '0) |-> (ramWe == '1 && ramEn && !ramRst));

  a_r6_quiet_ctrl: assert property (@(posedge clk) disable iff (rst)
    (ramWe == '0) |-> (!ramEn && ramRst));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ramEn && $past(ramEn)) |-> (ramAddr == $past(ramAddr) + BYTE_STEP));

  a_r4_data_step: assert property (@(posedge clk) disable iff (rst)
    (ramEn && $past(ramEn)) |-> (ramWrData == $past(ramWrData) + ledStep));

  a_r4_first_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(ramEn) |-> (ramAddr == '0 && ramWrData == '0));

  a_r5_led_hold: assert property (@(posedge clk) disable iff (rst)
    (ramEn && $past(ramEn)) |-> $stable(selLed));

  a_r7_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !ramEn |-> (ramAddr == '0 && ramWrData == '0));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !ramEn);

  a_r2_run_len: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (runCnt == RUN_W'(WORD_COUNT)));

  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    ramEn |-> (runCnt < RUN_W'(WORD_COUNT)));

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && !ramEn));

endmodule

bind seq_fill_writer seq_fill_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_COUNT(WORD_COUNT), .SEL_W(SEL_W),
  .STEP0(STEP0), .STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .ramEn     (ramEn),
  .ramRst    (ramRst),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .ramWrData (ramWrData),
  .selLed    (selLed),
  .done      (done)
);

// File: tb/tb_seq_fill_writer.sv
module tb_seq_fill_writer;

  localparam int NWORDS = 1000;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  stepSel;
  logic        ramEn, ramRst, done;
  logic [3:0]  ramWe;
  logic [31:0] ramAddr, ramWrData;
  logic [1:0]  selLed;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  seq_fill_writer dut (
    .clk(clk), .rst(rst), .start(start), .stepSel(stepSel),
    .ramEn(ramEn), .ramRst(ramRst), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .selLed(selLed), .done(done)
  );

  function automatic logic [31:0] stepOf(input logic [1:0] s);
    case (s)
      2'b00:   return 32'h0400_0004;
      2'b01:   return 32'h0404_0404;
      2'b10:   return 32'h0000_0004;
      default: return 32'h0000_0001;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // R10: outputs in the reset state
  task automatic checkResetState(input string req);
    check(done == 1'b0 && ramEn == 1'b0 && ramWe == 4'h0 && ramRst == 1'b1,
          req, "reset controls {done,en,we,rst}",
          {done, ramEn, ramWe, ramRst}, 7'b0000001);
    check(ramAddr == 32'h0 && ramWrData == 32'h0 && selLed == 2'b00,
          req, "reset bus and leds", {ramAddr, ramWrData, selLed}, 0);
  endtask

  // Follows one run from the trigger edge that was just set up.
  task automatic runCheck(input string tag, input logic [1:0] expSel,
                          input bit flipSw, input bit pokeStart);
    int cyc = 0, first = -1, idx = 0;
    int addrErr = 0, dataErr = 0, ctlErr = 0, ledErr = 0, busErr = 0;
    logic [31:0] expData = 32'h0;
    logic [31:0] badA = 0, badAe = 0, badD = 0, badDe = 0;
    while (!(done && idx > 0) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (ramEn) begin
        if (first < 0) first = cyc;
        if (ramAddr != 32'(idx * 4)) begin
          if (addrErr == 0) begin badA = ramAddr; badAe = 32'(idx * 4); end
          addrErr++;
        end
        if (ramWrData != expData) begin
          if (dataErr == 0) begin badD = ramWrData; badDe = expData; end
          dataErr++;
        end
        if (ramWe != 4'hF || ramRst != 1'b0) ctlErr++;
        if (selLed != expSel) ledErr++;
        expData = expData + stepOf(expSel);
        idx++;
        if (flipSw && idx == 300) stepSel = ~expSel;
        if (pokeStart && idx == 500) start = 1'b1;
      end else begin
        if (ramWe != 4'h0 || ramRst != 1'b1) ctlErr++;
        if (ramAddr != 32'h0 || ramWrData != 32'h0) busErr++;
      end
    end
    check(first == 2, "R1", {tag, " cycles to first write"}, first, 2);
    check(idx == NWORDS, "R2", {tag, " words written"}, idx, NWORDS);
    check(addrErr == 0, "R3", {tag, " first bad address"}, badA, badAe);
    check(dataErr == 0, "R4", {tag, " first bad data"}, badD, badDe);
    check(ledErr == 0, "R5", {tag, " led mismatches"}, ledErr, 0);
    check(ctlErr == 0, "R6", {tag, " port control mismatches"}, ctlErr, 0);
    check(busErr == 0, "R7", {tag, " nonzero idle bus cycles"}, busErr, 0);
    check(done == 1'b1 && ramEn == 1'b0, "R8", {tag, " done after last write"},
          {done, ramEn}, 2'b10);
  endtask

  // R8 / R5: done holds, nothing is written, switch moves are ignored.
  task automatic holdCheck(input logic [1:0] expSel);
    int errs = 0;
    for (int i = 0; i < 30; i++) begin
      stepSel = 2'(i);
      @(negedge clk);
      if (!done || ramEn || ramWe != 4'h0) errs++;
      if (selLed != expSel) errs++;
    end
    check(errs == 0, "R8", "done hold with switch moves (R5)", errs, 0);
  endtask

  // R9: start pulse from the finished state.
  task automatic kick(input logic [1:0] sel);
    stepSel = sel;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    check(done == 1'b0 && ramEn == 1'b0, "R9", "state after start edge",
          {done, ramEn}, 2'b00);
    // The clear cycle was entered; one more edge brings the first write.
    @(negedge clk);
    check(ramEn == 1'b1 && ramAddr == 0 && ramWrData == 0, "R9",
          "first write after start", {ramEn, ramAddr, ramWrData}, {1'b1, 64'h0});
  endtask

  // Runs the remainder of a run that kick() started (already one write seen).
  task automatic tailRun(input string tag, input logic [1:0] expSel,
                         input bit flipSw, input bit pokeStart);
    int idx = 1, errs = 0, cyc = 0;
    logic [31:0] expData = stepOf(expSel);
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (ramEn) begin
        if (ramAddr != 32'(idx * 4) || ramWrData != expData ||
            selLed != expSel || ramWe != 4'hF || ramRst) errs++;
        expData = expData + stepOf(expSel);
        idx++;
        if (flipSw && idx == 300) stepSel = ~expSel;
        if (pokeStart && idx == 500) start = 1'b1;
      end
    end
    check(idx == NWORDS, "R2", {tag, " words written"}, idx, NWORDS);
    check(errs == 0, "R4", {tag, " address/data/led/control mismatches (R3 R5 R6)"},
          errs, 0);
    check(done && !ramEn && ramAddr == 0 && ramWrData == 0, "R7",
          {tag, " quiet bus at done"}, {done, ramEn}, 2'b10);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; stepSel = 2'b00;
    repeat (3) @(negedge clk);
    checkResetState("R10");
    rst = 1'b0;
    runCheck("auto run sel00", 2'b00, 1'b0, 1'b0);
    holdCheck(2'b00);

    kick(2'b01);
    tailRun("restart sel01 with switch flip and start poke (R9)", 2'b01, 1'b1, 1'b1);
    kick(2'b10);
    tailRun("restart sel10", 2'b10, 1'b0, 1'b0);
    kick(2'b11);
    tailRun("restart sel11", 2'b11, 1'b0, 1'b0);

    // R10: reset in the middle of a run, then automatic rerun.
    kick(2'b01);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    stepSel = 2'b10;
    @(negedge clk);
    checkResetState("R10 mid-run");
    rst = 1'b0;
    runCheck("rerun after reset sel10", 2'b10, 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule